// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit virtual address into a physical address. It reads a two-level descriptor table held in memory and applies the domain and access-permission rules. A requester pulses `req_i` with the address, the access kind, the user flag and the translation context. The walker then issues at most two word reads over a request/valid memory port. It finishes with a one-cycle `done_o` pulse that carries either a physical address with read/write grants or an encoded fault status.

Low addresses are first relocated by the process identifier. With translation switched off, the walker returns the relocated address with full access and makes no memory read. First-level entries can be invalid, a 1 MB section, a coarse table or a fine table. Second-level entries map 64 KB, 4 KB or 1 KB pages. For the larger pages, the address picks one of four permission fields.

Top module: `pgw_walker`

## Requirements
- R1: An address below 0x0200_0000 has `pid_i` added to it (32-bit sum) before any other step; an address at or above that limit is used unchanged.
- R2: With `mmu_on_i` low, `pa_o` is the relocated address, both grants are high, there is no fault, and no memory read is issued.
- R3: The first read goes to `{tbl_base_i[31:14], mva[31:20], 2'b00}`. A first-level type (bits [1:0]) of 0 faults with code 5. `fsr_o` is always `{domain, code}`, where the domain number is descriptor bits [8:5].
- R4: The 2-bit domain field is `dom_ctl_i[2d+1:2d]`. A value of 0 or 2 faults without a second read: code 9 for a section (type 2), code 11 for a table (type 1 or 3). A value of 3 grants read and write with no permission check.
- R5: A section maps `{desc[31:20], mva[19:0]}` and takes its permission field from bits [11:10]. A denial faults with code 13.
- R6: The second read goes to `{desc[31:10], mva[19:12], 2'b00}`. A second-level type of 0 faults with code 7. A 1 KB page (type 3) under a coarse table (first-level type 1) also faults with code 7. Under a fine table (type 3) it is valid.
- R7: A 64 KB page (type 1) maps `{desc[31:16], mva[15:0]}` and a 4 KB page (type 2) maps `{desc[31:12], mva[11:0]}`. Both take the permission field at bit 4 + 2*mva[15:14]. A denial faults with code 15.
- R8: A 1 KB page maps `{desc[31:10], mva[9:0]}` with the permission field at bits [5:4].
- R9: Permission field 0 denies writes. For reads it uses `rom_sys_i`: 1 gives a privileged-only read, 2 gives read for everyone, and 0 or 3 give no access.
- R10: Permission field 1 gives read and write to privileged accesses only. Field 2 gives read and write to privileged accesses and read-only to user accesses. Field 3 gives read and write to all. Access kind 1 is a write; kinds 0 (read) and 2 (fetch) are reads. A granted write always comes with a granted read.
- R11: `mem_req_o` stays high with a stable `mem_addr_o` until `mem_valid_i`. `mem_valid_i` has no effect while no request is open.
- R12: `done_o` is a one-cycle pulse. `fault_o` is high only with it. On a fault both grants are low. Results hold until the next request, and everything is zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a walk (taken when idle) |
| va_i | input | 32 | Virtual address |
| acc_i | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| user_i | input | 1 | Unprivileged access |
| mmu_on_i | input | 1 | Translation enable |
| rom_sys_i | input | 2 | Read rule for permission field 0 |
| pid_i | input | 32 | Process relocation offset |
| tbl_base_i | input | 18 | First-level table base, address bits 31:14 |
| dom_ctl_i | input | 32 | Sixteen 2-bit domain fields |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Memory read word address |
| mem_valid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| done_o | output | 1 | Walk finished (one cycle) |
| fault_o | output | 1 | Walk ended in a fault |
| pa_o | output | 32 | Physical address |
| perm_rd_o | output | 1 | Read granted |
| perm_wr_o | output | 1 | Write granted |
| fsr_o | output | 8 | Fault status {domain, code} |

## Verification
The bench aims at permission-field selection inside a large page. A walker that ignored mva[15:14] would grant where the selected field denies, or the reverse. It checks that a 1 KB entry faults under a coarse table but maps under a fine one; a design missing that rule would return a bogus address. The domain checks must fire before a second read and must bypass the permission check in manager domains; the bench counts the reads each walk makes to catch an extra or missing one. It also probes the relocation limit on both sides and reuses one section with each read-rule setting, so an off-by-one compare or a swapped rule shows up as a wrong grant.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  localparam int unsigned AW      = 32;
  localparam int unsigned CODE_W  = 4;
  localparam int unsigned DOM_W   = 4;
  localparam int unsigned FSR_W   = CODE_W + DOM_W;

  localparam logic [CODE_W-1:0] C_L1_XLAT  = 4'd5;
  localparam logic [CODE_W-1:0] C_L2_XLAT  = 4'd7;
  localparam logic [CODE_W-1:0] C_SECT_DOM = 4'd9;
  localparam logic [CODE_W-1:0] C_PAGE_DOM = 4'd11;
  localparam logic [CODE_W-1:0] C_SECT_AP  = 4'd13;
  localparam logic [CODE_W-1:0] C_PAGE_AP  = 4'd15;

  localparam logic [1:0] DOM_NONE = 2'd0;
  localparam logic [1:0] DOM_RSVD = 2'd2;
  localparam logic [1:0] DOM_MGR  = 2'd3;

  typedef enum logic [1:0] {ACC_READ = 2'd0, ACC_WRITE = 2'd1, ACC_FETCH = 2'd2} acc_e;
  typedef enum logic [1:0] {L1K_FAULT, L1K_SECT, L1K_TABLE} l1_kind_e;
  typedef enum logic [1:0] {ST_IDLE, ST_L1, ST_L2, ST_DONE} walk_st_e;
endpackage

// File: rtl/pgw_reloc.sv
module pgw_reloc #(
  parameter int unsigned AW    = 32,
  parameter logic [AW-1:0] LIMIT = 32'h0200_0000
) (
  input  logic [AW-1:0] va_i,
  input  logic [AW-1:0] pid_i,
  output logic [AW-1:0] mva_o
);
  assign mva_o = (va_i < LIMIT) ? va_i + pid_i : va_i;
endmodule

// File: rtl/pgw_perm.sv
module pgw_perm (
  input  logic [1:0] ap_i,
  input  logic [1:0] dom_fld_i,
  input  logic       wr_i,
  input  logic       user_i,
  input  logic [1:0] rom_sys_i,
  output logic       rd_o,
  output logic       wr_o
);
  import pgw_pkg::*;
  always_comb begin
    rd_o = 1'b0;
    wr_o = 1'b0;
    if (dom_fld_i == DOM_MGR) begin
      rd_o = 1'b1;
      wr_o = 1'b1;
    end else begin
      case (ap_i)
        2'd0: if (!wr_i) begin
          case (rom_sys_i)
            2'd1:    rd_o = !user_i;
            2'd2:    rd_o = 1'b1;
            default: rd_o = 1'b0;
          endcase
        end
        2'd1: begin
          rd_o = !user_i;
          wr_o = !user_i;
        end
        2'd2: begin
          if (user_i) rd_o = !wr_i;
          else begin
            rd_o = 1'b1;
            wr_o = 1'b1;
          end
        end
        default: begin
          rd_o = 1'b1;
          wr_o = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/pgw_l1_dec.sv
module pgw_l1_dec
  import pgw_pkg::*;
(
  input  logic [31:0]       desc_i,
  input  logic [31:0]       mva_i,
  input  logic [31:0]       dom_ctl_i,
  output l1_kind_e          kind_o,
  output logic [CODE_W-1:0] code_o,
  output logic [DOM_W-1:0]  dom_num_o,
  output logic [1:0]        dom_fld_o,
  output logic [1:0]        ap_o,
  output logic [31:0]       sect_pa_o,
  output logic [31:0]       l2_addr_o,
  output logic              fine_o
);
  logic [1:0] typ;
  logic       unused_l1_bits;

  assign typ            = desc_i[1:0];
  assign dom_num_o      = desc_i[8:5];
  assign dom_fld_o      = dom_ctl_i[{dom_num_o, 1'b0} +: 2];
  assign ap_o           = desc_i[11:10];
  assign sect_pa_o      = {desc_i[31:20], mva_i[19:0]};
  assign l2_addr_o      = {desc_i[31:10], mva_i[19:12], 2'b00};
  assign fine_o         = (typ == 2'd3);
  assign unused_l1_bits = ^{desc_i[19:12], desc_i[9], desc_i[4:2], mva_i[31:20]};

  always_comb begin
    kind_o = L1K_FAULT;
    code_o = C_L1_XLAT;
    if (typ == 2'd0) begin
      kind_o = L1K_FAULT;
      code_o = C_L1_XLAT;
    end else if (dom_fld_o == DOM_NONE || dom_fld_o == DOM_RSVD) begin
      kind_o = L1K_FAULT;
      code_o = (typ == 2'd2) ? C_SECT_DOM : C_PAGE_DOM;
    end else if (typ == 2'd2) begin
      kind_o = L1K_SECT;
      code_o = C_SECT_AP;
    end else begin
      kind_o = L1K_TABLE;
      code_o = C_PAGE_AP;
    end
  end
endmodule

// File: rtl/pgw_l2_dec.sv
module pgw_l2_dec (
  input  logic [31:0] desc_i,
  input  logic [15:0] mva_i,
  input  logic        fine_i,
  output logic        xlat_fault_o,
  output logic [1:0]  ap_o,
  output logic [31:0] pa_o
);
  logic [1:0] typ;
  logic [1:0] sub;
  logic       unused_l2_bits;

  assign typ            = desc_i[1:0];
  assign sub            = mva_i[15:14];
  assign unused_l2_bits = ^desc_i[3:2];

  always_comb begin
    xlat_fault_o = 1'b0;
    ap_o         = desc_i[{1'b0, sub, 1'b0} + 4'd4 +: 2];
    pa_o         = '0;
    case (typ)
      2'd0: xlat_fault_o = 1'b1;
      2'd1: pa_o = {desc_i[31:16], mva_i[15:0]};
      2'd2: pa_o = {desc_i[31:12], mva_i[11:0]};
      default: begin
        xlat_fault_o = !fine_i;
        ap_o         = desc_i[5:4];
        pa_o         = {desc_i[31:10], mva_i[9:0]};
      end
    endcase
  end
endmodule

// File: rtl/pgw_walker.sv
module pgw_walker
  import pgw_pkg::*;
#(
  parameter logic [31:0] RELOC_LIMIT = 32'h0200_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [31:0]       va_i,
  input  logic [1:0]        acc_i,
  input  logic              user_i,
  input  logic              mmu_on_i,
  input  logic [1:0]        rom_sys_i,
  input  logic [31:0]       pid_i,
  input  logic [31:14]      tbl_base_i,
  input  logic [31:0]       dom_ctl_i,
  output logic              mem_req_o,
  output logic [31:0]       mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              done_o,
  output logic              fault_o,
  output logic [31:0]       pa_o,
  output logic              perm_rd_o,
  output logic              perm_wr_o,
  output logic [FSR_W-1:0]  fsr_o
);
  walk_st_e          st_q;
  logic [31:0]       mva, mva_q;
  logic [31:14]      tbase_q;
  logic [31:0]       dom_ctl_q;
  logic [1:0]        rom_sys_q;
  logic              wr_req_q, user_q, fine_q;
  logic [DOM_W-1:0]  dom_num_q;
  logic [1:0]        dom_fld_q;
  logic [31:0]       l2a_q;
  logic [31:0]       pa_q;
  logic              rd_q, wr_q, fault_q;
  logic [FSR_W-1:0]  fsr_q;

  l1_kind_e          l1_kind;
  logic [CODE_W-1:0] l1_code;
  logic [DOM_W-1:0]  l1_dom;
  logic [1:0]        l1_fld, l1_ap;
  logic [31:0]       l1_pa, l1_l2a;
  logic              l1_fine;
  logic              l2_xf;
  logic [1:0]        l2_ap;
  logic [31:0]       l2_pa;
  logic [1:0]        chk_ap, chk_fld;
  logic              p_rd, p_wr;

  pgw_reloc #(.AW(AW), .LIMIT(RELOC_LIMIT)) u_reloc (
    .va_i(va_i), .pid_i(pid_i), .mva_o(mva)
  );

  pgw_l1_dec u_l1 (
    .desc_i(mem_rdata_i), .mva_i(mva_q), .dom_ctl_i(dom_ctl_q),
    .kind_o(l1_kind), .code_o(l1_code), .dom_num_o(l1_dom), .dom_fld_o(l1_fld),
    .ap_o(l1_ap), .sect_pa_o(l1_pa), .l2_addr_o(l1_l2a), .fine_o(l1_fine)
  );

  pgw_l2_dec u_l2 (
    .desc_i(mem_rdata_i), .mva_i(mva_q[15:0]), .fine_i(fine_q),
    .xlat_fault_o(l2_xf), .ap_o(l2_ap), .pa_o(l2_pa)
  );

  // one checker serves both levels
  assign chk_ap  = (st_q == ST_L2) ? l2_ap : l1_ap;
  assign chk_fld = (st_q == ST_L2) ? dom_fld_q : l1_fld;

  pgw_perm u_perm (
    .ap_i(chk_ap), .dom_fld_i(chk_fld), .wr_i(wr_req_q), .user_i(user_q),
    .rom_sys_i(rom_sys_q), .rd_o(p_rd), .wr_o(p_wr)
  );

  assign mem_req_o  = (st_q == ST_L1) || (st_q == ST_L2);
  assign mem_addr_o = (st_q == ST_L2) ? l2a_q : {tbase_q, mva_q[31:20], 2'b00};
  assign done_o     = (st_q == ST_DONE);
  assign fault_o    = done_o && fault_q;
  assign pa_o       = pa_q;
  assign perm_rd_o  = rd_q;
  assign perm_wr_o  = wr_q;
  assign fsr_o      = fsr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      mva_q     <= '0;
      tbase_q   <= '0;
      dom_ctl_q <= '0;
      rom_sys_q <= '0;
      wr_req_q  <= 1'b0;
      user_q    <= 1'b0;
      fine_q    <= 1'b0;
      dom_num_q <= '0;
      dom_fld_q <= '0;
      l2a_q     <= '0;
      pa_q      <= '0;
      rd_q      <= 1'b0;
      wr_q      <= 1'b0;
      fault_q   <= 1'b0;
      fsr_q     <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_i) begin
          mva_q     <= mva;
          tbase_q   <= tbl_base_i;
          dom_ctl_q <= dom_ctl_i;
          rom_sys_q <= rom_sys_i;
          wr_req_q  <= (acc_i == ACC_WRITE);
          user_q    <= user_i;
          fault_q   <= 1'b0;
          fsr_q     <= '0;
          if (!mmu_on_i) begin
            pa_q <= mva;
            rd_q <= 1'b1;
            wr_q <= 1'b1;
            st_q <= ST_DONE;
          end else begin
            pa_q <= '0;
            rd_q <= 1'b0;
            wr_q <= 1'b0;
            st_q <= ST_L1;
          end
        end
        ST_L1: if (mem_valid_i) begin
          dom_num_q <= l1_dom;
          dom_fld_q <= l1_fld;
          case (l1_kind)
            L1K_SECT: begin
              st_q <= ST_DONE;
              if (p_rd) begin
                pa_q <= l1_pa;
                rd_q <= p_rd;
                wr_q <= p_wr;
              end else begin
                fault_q <= 1'b1;
                fsr_q   <= {l1_dom, C_SECT_AP};
              end
            end
            L1K_TABLE: begin
              l2a_q  <= l1_l2a;
              fine_q <= l1_fine;
              st_q   <= ST_L2;
            end
            default: begin
              fault_q <= 1'b1;
              fsr_q   <= {l1_dom, l1_code};
              st_q    <= ST_DONE;
            end
          endcase
        end
        ST_L2: if (mem_valid_i) begin
          st_q <= ST_DONE;
          if (l2_xf) begin
            fault_q <= 1'b1;
            fsr_q   <= {dom_num_q, C_L2_XLAT};
          end else if (p_rd) begin
            pa_q <= l2_pa;
            rd_q <= p_rd;
            wr_q <= p_wr;
          end else begin
            fault_q <= 1'b1;
            fsr_q   <= {dom_num_q, C_PAGE_AP};
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pgw_walker_chk.sv
module pgw_walker_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mem_req_o,
  input logic        mem_valid_i,
  input logic [31:0] mem_addr_o,
  input logic        done_o,
  input logic        fault_o,
  input logic        perm_rd_o,
  input logic        perm_wr_o,
  input logic [7:0]  fsr_o
);
  p_req_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  p_done_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_fault_with_done_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (done_o && !perm_rd_o && !perm_wr_o));

  p_no_req_at_done_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_req_o);

  p_fault_code_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (fsr_o[3:0] inside {4'd5, 4'd7, 4'd9, 4'd11, 4'd13, 4'd15}));

  p_grant_has_read_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fault_o) |-> perm_rd_o);

  p_write_implies_read_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perm_wr_o |-> perm_rd_o);
endmodule

bind pgw_walker pgw_walker_chk u_chk (.*);

// File: tb/pgw_walker_tb.sv
`timescale 1ns/1ps
module pgw_walker_tb;
  typedef struct packed {
    logic [31:0] tag;
    logic [31:0] va;
    logic [1:0]  acc;
    logic        usr;
    logic [31:0] ctrl;
    logic [31:0] pid;
    logic [31:0] l1a;
    logic [31:0] l1d;
    logic [31:0] l2a;
    logic [31:0] l2d;
    logic [1:0]  lat;
    logic [1:0]  nrd;
    logic        flt;
    logic [7:0]  fsr;
    logic [31:0] pa;
    logic        rd;
    logic        wr;
  } vec_t;

  localparam logic [31:0] DOMS = 32'h0000_018D; // d0 client, d1 mgr, d2 none, d3 rsvd, d4 client
  localparam int NV = 25;
  // tag, va, acc, usr, ctrl, pid, l1a, l1d, l2a, l2d, lat, nrd, flt, fsr, pa, rd, wr
  localparam vec_t VEC [NV] = '{
    '{"R5",  32'h1234_5678, 2'd0, 1'b1, 32'h1, 32'h0, 32'h448C, 32'hABC0_0C02, 32'h0, 32'h0, 2'd0, 2'd1, 1'b0, 8'h00, 32'hABC4_5678, 1'b1, 1'b1},
    '{"R10", 32'h3000_0010, 2'd1, 1'b1, 32'h1, 32'h0, 32'h4C00, 32'h5550_0802, 32'h0, 32'h0, 2'd1, 2'd1, 1'b1, 8'h0D, 32'h0, 1'b0, 1'b0},
    '{"R10", 32'h3000_0010, 2'd0, 1'b1, 32'h1, 32'h0, 32'h4C00, 32'h5550_0802, 32'h0, 32'h0, 2'd2, 2'd1, 1'b0, 8'h00, 32'h5550_0010, 1'b1, 1'b0},
    '{"R10", 32'h4000_0000, 2'd0, 1'b1, 32'h1, 32'h0, 32'h5000, 32'h6660_0482, 32'h0, 32'h0, 2'd0, 2'd1, 1'b1, 8'h4D, 32'h0, 1'b0, 1'b0},
    '{"R10", 32'h4000_0000, 2'd1, 1'b0, 32'h1, 32'h0, 32'h5000, 32'h6660_0482, 32'h0, 32'h0, 2'd3, 2'd1, 1'b0, 8'h00, 32'h6660_0000, 1'b1, 1'b1},
    '{"R4",  32'h5001_2345, 2'd1, 1'b1, 32'h1, 32'h0, 32'h5400, 32'h7770_0022, 32'h0, 32'h0, 2'd0, 2'd1, 1'b0, 8'h00, 32'h7771_2345, 1'b1, 1'b1},
    '{"R3",  32'h6000_0000, 2'd0, 1'b0, 32'h1, 32'h0, 32'h5800, 32'h0000_0060, 32'h0, 32'h0, 2'd1, 2'd1, 1'b1, 8'h35, 32'h0, 1'b0, 1'b0},
    '{"R4",  32'h7000_0000, 2'd0, 1'b0, 32'h1, 32'h0, 32'h5C00, 32'h1230_0042, 32'h0, 32'h0, 2'd0, 2'd1, 1'b1, 8'h29, 32'h0, 1'b0, 1'b0},
    '{"R4",  32'h7100_0000, 2'd0, 1'b0, 32'h1, 32'h0, 32'h5C40, 32'h0000_0061, 32'h0, 32'h0, 2'd2, 2'd1, 1'b1, 8'h3B, 32'h0, 1'b0, 1'b0},
    '{"R7",  32'h8003_4ABC, 2'd1, 1'b1, 32'h1, 32'h0, 32'h6000, 32'h0008_0401, 32'h0008_04D0, 32'h9999_90C2, 2'd1, 2'd2, 1'b0, 8'h00, 32'h9999_9ABC, 1'b1, 1'b1},
    '{"R7",  32'h8003_4ABC, 2'd1, 1'b1, 32'h1, 32'h0, 32'h6000, 32'h0008_0401, 32'h0008_04D0, 32'h9999_9032, 2'd0, 2'd2, 1'b1, 8'h0F, 32'h0, 1'b0, 1'b0},
    '{"R7",  32'h9012_C678, 2'd0, 1'b1, 32'h1, 32'h0, 32'h6404, 32'h0008_0881, 32'h0008_08B0, 32'hABCD_0801, 2'd3, 2'd2, 1'b0, 8'h00, 32'hABCD_C678, 1'b1, 1'b0},
    '{"R6",  32'h9012_C678, 2'd0, 1'b1, 32'h1, 32'h0, 32'h6404, 32'h0008_0881, 32'h0008_08B0, 32'hFFFF_FFF0, 2'd0, 2'd2, 1'b1, 8'h47, 32'h0, 1'b0, 1'b0},
    '{"R6",  32'h9012_C678, 2'd0, 1'b0, 32'h1, 32'h0, 32'h6404, 32'h0008_0881, 32'h0008_08B0, 32'h1234_5C33, 2'd1, 2'd2, 1'b1, 8'h47, 32'h0, 1'b0, 1'b0},
    '{"R8",  32'hA00F_F3FF, 2'd1, 1'b0, 32'h1, 32'h0, 32'h6800, 32'h000C_0003, 32'h000C_03FC, 32'h5555_6423, 2'd2, 2'd2, 1'b0, 8'h00, 32'h5555_67FF, 1'b1, 1'b1},
    '{"R9",  32'hB000_0004, 2'd0, 1'b0, 32'h101, 32'h0, 32'h6C00, 32'h2220_0002, 32'h0, 32'h0, 2'd0, 2'd1, 1'b0, 8'h00, 32'h2220_0004, 1'b1, 1'b0},
    '{"R9",  32'hB000_0004, 2'd0, 1'b1, 32'h101, 32'h0, 32'h6C00, 32'h2220_0002, 32'h0, 32'h0, 2'd1, 2'd1, 1'b1, 8'h0D, 32'h0, 1'b0, 1'b0},
    '{"R9",  32'hB000_0004, 2'd2, 1'b1, 32'h201, 32'h0, 32'h6C00, 32'h2220_0002, 32'h0, 32'h0, 2'd0, 2'd1, 1'b0, 8'h00, 32'h2220_0004, 1'b1, 1'b0},
    '{"R9",  32'hB000_0004, 2'd1, 1'b0, 32'h201, 32'h0, 32'h6C00, 32'h2220_0002, 32'h0, 32'h0, 2'd2, 2'd1, 1'b1, 8'h0D, 32'h0, 1'b0, 1'b0},
    '{"R9",  32'hB000_0004, 2'd0, 1'b0, 32'h301, 32'h0, 32'h6C00, 32'h2220_0002, 32'h0, 32'h0, 2'd0, 2'd1, 1'b1, 8'h0D, 32'h0, 1'b0, 1'b0},
    '{"R2",  32'h0100_0000, 2'd1, 1'b1, 32'h0, 32'h0600_0000, 32'h0, 32'h0, 32'h0, 32'h0, 2'd0, 2'd0, 1'b0, 8'h00, 32'h0700_0000, 1'b1, 1'b1},
    '{"R1",  32'h0010_0ABC, 2'd0, 1'b0, 32'h1, 32'h0400_0000, 32'h4104, 32'h3330_0C02, 32'h0, 32'h0, 2'd1, 2'd1, 1'b0, 8'h00, 32'h3330_0ABC, 1'b1, 1'b1},
    '{"R1",  32'h0200_0000, 2'd0, 1'b0, 32'h0, 32'h0400_0000, 32'h0, 32'h0, 32'h0, 32'h0, 2'd0, 2'd0, 1'b0, 8'h00, 32'h0200_0000, 1'b1, 1'b1},
    '{"R1",  32'h01FF_FFFF, 2'd0, 1'b0, 32'h0, 32'h0200_0000, 32'h0, 32'h0, 32'h0, 32'h0, 2'd0, 2'd0, 1'b0, 8'h00, 32'h03FF_FFFF, 1'b1, 1'b1},
    '{"R10", 32'h3000_0010, 2'd2, 1'b1, 32'h1, 32'h0, 32'h4C00, 32'h5550_0802, 32'h0, 32'h0, 2'd3, 2'd1, 1'b0, 8'h00, 32'h5550_0010, 1'b1, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [31:0] va_i = '0;
  logic [1:0]  acc_i = '0;
  logic        user_i = 1'b0;
  logic        mmu_on_i = 1'b0;
  logic [1:0]  rom_sys_i = '0;
  logic [31:0] pid_i = '0;
  logic [31:14] tbl_base_i = 18'h1;
  logic [31:0] dom_ctl_i = DOMS;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_valid_i;
  logic [31:0] mem_rdata_i;
  logic        done_o, fault_o, perm_rd_o, perm_wr_o;
  logic [31:0] pa_o;
  logic [7:0]  fsr_o;

  logic        mv_model = 1'b0;
  logic        force_v = 1'b0;
  logic [31:0] rdata_model = '0;
  int          nreads = 0;
  int          wait_cnt = 0;
  vec_t        cur = '0;
  int          checks = 0;
  int          failures = 0;
  bit          finished = 1'b0;

  assign mem_valid_i = mv_model | force_v;
  assign mem_rdata_i = rdata_model;

  always #5 clk = ~clk;

  pgw_walker u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .va_i(va_i), .acc_i(acc_i),
    .user_i(user_i), .mmu_on_i(mmu_on_i), .rom_sys_i(rom_sys_i), .pid_i(pid_i),
    .tbl_base_i(tbl_base_i), .dom_ctl_i(dom_ctl_i), .mem_req_o(mem_req_o),
    .mem_addr_o(mem_addr_o), .mem_valid_i(mem_valid_i), .mem_rdata_i(mem_rdata_i),
    .done_o(done_o), .fault_o(fault_o), .pa_o(pa_o), .perm_rd_o(perm_rd_o),
    .perm_wr_o(perm_wr_o), .fsr_o(fsr_o)
  );

  // memory model: answers after cur.lat waiting cycles
  always @(negedge clk) begin
    if (mem_req_o && wait_cnt >= int'(cur.lat)) begin
      mv_model    = 1'b1;
      rdata_model = (mem_addr_o == cur.l1a) ? cur.l1d :
                    (mem_addr_o == cur.l2a) ? cur.l2d : 32'h0;
      nreads      = nreads + 1;
      wait_cnt    = 0;
    end else begin
      mv_model = 1'b0;
      if (mem_req_o) wait_cnt = wait_cnt + 1;
    end
  end

  task automatic chk(input logic [31:0] tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic run_vec(input int idx);
    vec_t v;
    int   base;
    int   n;
    v = VEC[idx];
    @(negedge clk);
    cur       = v;
    va_i      = v.va;
    acc_i     = v.acc;
    user_i    = v.usr;
    mmu_on_i  = v.ctrl[0];
    rom_sys_i = v.ctrl[9:8];
    pid_i     = v.pid;
    req_i     = 1'b1;
    base      = nreads;
    @(negedge clk);
    req_i = 1'b0;
    n = 0;
    while (!done_o && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk(v.tag, "done seen (R12)", {31'b0, done_o}, 32'd1);
    chk(v.tag, "fault", {31'b0, fault_o}, {31'b0, v.flt});
    chk(v.tag, "fsr", {24'b0, fsr_o}, {24'b0, v.fsr});
    chk(v.tag, "pa", pa_o, v.pa);
    chk(v.tag, "read grant", {31'b0, perm_rd_o}, {31'b0, v.rd});
    chk(v.tag, "write grant", {31'b0, perm_wr_o}, {31'b0, v.wr});
    chk(v.tag, "memory reads", nreads - base, {30'b0, v.nrd});
    @(negedge clk);
    chk("R12", "done pulse width", {31'b0, done_o}, 32'd0);
    chk("R12", "result held", pa_o, v.pa);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12", "reset done", {31'b0, done_o}, 32'd0);
    chk("R12", "reset fault", {31'b0, fault_o}, 32'd0);
    chk("R11", "reset mem_req", {31'b0, mem_req_o}, 32'd0);
    chk("R12", "reset pa", pa_o, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R11: stray valid while idle has no effect
    force_v = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R11", "idle valid done", {31'b0, done_o}, 32'd0);
      chk("R11", "idle valid req", {31'b0, mem_req_o}, 32'd0);
    end
    force_v = 1'b0;
    chk("R11", "idle valid keeps result", pa_o, VEC[NV-1].pa);
    run_vec(9);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R12 watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule